// File: doc/BRIEF.md
# Speculative Load Alias Check Table

The block tracks loads that a compiler has moved above stores that might write the same memory. When such an advanced load issues, it records its destination register and the aligned 8-byte block of its address. Every later store is snooped against all recorded blocks in parallel, and each entry whose block it hits is marked invalid. At the load's original place in the program, a check names the destination register. The check passes only if an entry for that register is present and still valid. A failing check, for a missing or an invalidated entry, tells the pipeline to run fixup code.

Each destination register has at most one entry. Free slots are filled lowest index first. When all slots are in use, a round-robin pointer picks the slot to evict. A passing check consumes its entry. A flush empties the table. The check response is registered and appears one cycle after the request. It reflects the table as it stood before that cycle's updates.

Top module: `ld_alias_table`

## Requirements
- R1: A check with `chk_valid_i` high in cycle t produces `chk_valid_o` high in cycle t+1 only. An entry inserted through `ld_valid_i` and not touched since then gives `chk_hit_o`=1 and `chk_pass_o`=1.
- R2: A store whose address lies in the same 8-byte block as an entry (bits [ADDR_W-1:3] equal) invalidates that entry. A later check then gives `chk_hit_o`=1 and `chk_pass_o`=0.
- R3: A store to a different 8-byte block leaves an entry valid.
- R4: One store invalidates, in the same cycle, every entry whose block it hits.
- R5: An insert for a register that already has an entry overwrites that entry in place with the new block, and the entry becomes valid.
- R6: The table holds NUM_ENTRIES entries, 8 by default. Free slots are filled lowest index first. An insert into a full table for a new register evicts the slot at a round-robin pointer. The pointer starts at slot 0 and advances by one after each eviction. An evicted register checks as missing (`chk_hit_o`=0).
- R7: A passing check removes its entry, so a repeated check misses. A failing check on an invalid entry leaves that entry in place.
- R8: `flush_i` clears every entry and returns the round-robin pointer to slot 0.
- R9: An insert together with a store to the same block in the same cycle leaves the new entry present but invalid.
- R10: A check response shows the state before the same cycle's insert, store or removal. After reset `chk_valid_o` is 0 and every register misses.
- R11: A check for a register that has never been inserted gives `chk_hit_o`=0 and `chk_pass_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clears all entries |
| ld_valid_i | input | 1 | Advanced load insert strobe |
| ld_reg_i | input | REG_W | Destination register of the advanced load |
| ld_addr_i | input | ADDR_W | Byte address of the advanced load |
| st_valid_i | input | 1 | Store snoop strobe |
| st_addr_i | input | ADDR_W | Byte address of the store |
| chk_valid_i | input | 1 | Check request strobe |
| chk_reg_i | input | REG_W | Register to check |
| chk_valid_o | output | 1 | Check response valid, one cycle after the request |
| chk_hit_o | output | 1 | An entry for the register was present |
| chk_pass_o | output | 1 | The entry was present and valid; fixup is not needed |

## Verification
Wrong table state stays hidden until a check names the affected register. A missed invalidation then shows up as a false pass in the cycle after the check. A wrongly dropped or evicted entry shows up as a miss. Because a passing check consumes its entry, the bench checks every stored entry at a chosen moment. It mixes reuse, eviction order and flush so that a pointer or priority error changes which register misses.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [1:0] {
    SRC_REUSE = 2'd0,
    SRC_FREE  = 2'd1,
    SRC_EVICT = 2'd2
  } slot_src_e;
endpackage

// File: rtl/lat_lookup.sv
module lat_lookup #(
  parameter int N     = 8,
  parameter int KEY_W = 7
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] keys_i [N],
  input  logic [N-1:0]     en_i,
  output logic [N-1:0]     hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = en_i[g] && (keys_i[g] == key_i);
  end
endmodule

// File: rtl/lat_alloc.sv
module lat_alloc
  import lat_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             ins_i,
  input  logic [N-1:0]     reuse_i,
  input  logic [N-1:0]     occ_i,
  output logic [IDX_W-1:0] slot_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] reuse_idx, free_idx;
  slot_src_e        src;

  always_comb begin
    reuse_idx = '0;
    for (int i = 0; i < N; i++) if (reuse_i[i]) reuse_idx = IDX_W'(i);
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) if (!occ_i[i]) free_idx = IDX_W'(i);
    if (|reuse_i) begin
      src    = SRC_REUSE;
      slot_o = reuse_idx;
    end else if (!(&occ_i)) begin
      src    = SRC_FREE;
      slot_o = free_idx;
    end else begin
      src    = SRC_EVICT;
      slot_o = rr_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rr_q <= '0;
    else if (flush_i)                     rr_q <= '0;
    else if (ins_i && src == SRC_EVICT)   rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  // R5: one entry per register
  a_r5_unique_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reuse_i));
  a_r6_rr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_q <= IDX_W'(N - 1));
  a_r8_rr_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> rr_q == '0);
endmodule

// File: rtl/lat_entries.sv
module lat_entries #(
  parameter int N     = 8,
  parameter int REG_W = 7,
  parameter int KEY_W = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             ins_i,
  input  logic [IDX_W-1:0] ins_slot_i,
  input  logic [REG_W-1:0] ins_reg_i,
  input  logic [KEY_W-1:0] ins_blk_i,
  input  logic             ins_killed_i,
  input  logic [N-1:0]     st_hit_i,
  input  logic [N-1:0]     clr_i,
  output logic [N-1:0]     occ_o,
  output logic [N-1:0]     vld_o,
  output logic [REG_W-1:0] tag_o [N],
  output logic [KEY_W-1:0] blk_o [N]
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic wr;
    assign wr = ins_i && (ins_slot_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ_o[g] <= 1'b0;
        vld_o[g] <= 1'b0;
        tag_o[g] <= '0;
        blk_o[g] <= '0;
      end else if (flush_i) begin
        occ_o[g] <= 1'b0;
        vld_o[g] <= 1'b0;
      end else if (wr) begin
        occ_o[g] <= 1'b1;
        vld_o[g] <= !ins_killed_i;
        tag_o[g] <= ins_reg_i;
        blk_o[g] <= ins_blk_i;
      end else if (clr_i[g]) begin
        occ_o[g] <= 1'b0;
        vld_o[g] <= 1'b0;
      end else if (st_hit_i[g]) begin
        vld_o[g] <= 1'b0;
      end
    end
  end

  a_r8_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> occ_o == '0);
  a_r2_vld_in_occ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o & ~occ_o) == '0);
endmodule

// File: rtl/ld_alias_table.sv
module ld_alias_table #(
  parameter int NUM_ENTRIES = 8,
  parameter int REG_W       = 7,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BYTES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              ld_valid_i,
  input  logic [REG_W-1:0]  ld_reg_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              chk_valid_i,
  input  logic [REG_W-1:0]  chk_reg_i,
  output logic              chk_valid_o,
  output logic              chk_hit_o,
  output logic              chk_pass_o
);
  localparam int N     = NUM_ENTRIES;
  localparam int IDX_W = $clog2(N);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(GRAN_BYTES - 1);

  logic [N-1:0]      occ_w, vld_w;
  logic [REG_W-1:0]  tag_w [N];
  logic [ADDR_W-1:0] blk_w [N];
  logic [ADDR_W-1:0] ld_blk, st_blk;
  logic [N-1:0]      reuse_vec, chk_vec, st_vec, clr_vec;
  logic [IDX_W-1:0]  ins_slot;
  logic              ins_killed;

  assign ld_blk     = ld_addr_i & BLK_MASK;
  assign st_blk     = st_addr_i & BLK_MASK;
  assign ins_killed = st_valid_i && (st_blk == ld_blk);

  lat_lookup #(.N(N), .KEY_W(REG_W)) u_reuse (
    .key_i(ld_reg_i), .keys_i(tag_w), .en_i(occ_w), .hit_o(reuse_vec));

  lat_lookup #(.N(N), .KEY_W(REG_W)) u_chk (
    .key_i(chk_reg_i), .keys_i(tag_w), .en_i(occ_w), .hit_o(chk_vec));

  lat_lookup #(.N(N), .KEY_W(ADDR_W)) u_snoop (
    .key_i(st_blk), .keys_i(blk_w), .en_i(occ_w & {N{st_valid_i}}), .hit_o(st_vec));

  assign clr_vec = chk_valid_i ? (chk_vec & vld_w) : '0;

  lat_alloc #(.N(N), .IDX_W(IDX_W)) u_alloc (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .ins_i(ld_valid_i),
    .reuse_i(reuse_vec), .occ_i(occ_w), .slot_o(ins_slot));

  lat_entries #(.N(N), .REG_W(REG_W), .KEY_W(ADDR_W), .IDX_W(IDX_W)) u_ent (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .ins_i(ld_valid_i),
    .ins_slot_i(ins_slot), .ins_reg_i(ld_reg_i), .ins_blk_i(ld_blk),
    .ins_killed_i(ins_killed), .st_hit_i(st_vec), .clr_i(clr_vec),
    .occ_o(occ_w), .vld_o(vld_w), .tag_o(tag_w), .blk_o(blk_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_valid_o <= 1'b0;
      chk_hit_o   <= 1'b0;
      chk_pass_o  <= 1'b0;
    end else begin
      chk_valid_o <= chk_valid_i;
      chk_hit_o   <= chk_valid_i && (|chk_vec);
      chk_pass_o  <= chk_valid_i && (|(chk_vec & vld_w));
    end
  end

  function automatic logic blk_alive(input logic [ADDR_W-1:0] b);
    logic r = 1'b0;
    for (int i = 0; i < N; i++) if (vld_w[i] && blk_w[i] == b) r = 1'b1;
    return r;
  endfunction

  function automatic logic reg_present(input logic [REG_W-1:0] r_in);
    logic r = 1'b0;
    for (int i = 0; i < N; i++) if (occ_w[i] && tag_w[i] == r_in) r = 1'b1;
    return r;
  endfunction

  a_r1_resp_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i |=> chk_valid_o);
  a_r1_resp_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_valid_i |=> !chk_valid_o);
  a_r2_store_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |=> !blk_alive($past(st_addr_i) & BLK_MASK));
  a_r7_pass_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_pass_o && !$past(ld_valid_i) && !$past(flush_i) |-> !reg_present($past(chk_reg_i)));
  a_r10_pass_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_pass_o |-> chk_hit_o);
endmodule

// File: tb/tb_ld_alias_table.sv
module tb_ld_alias_table;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        ld_valid_i = 1'b0;
  logic [6:0]  ld_reg_i = '0;
  logic [31:0] ld_addr_i = '0;
  logic        st_valid_i = 1'b0;
  logic [31:0] st_addr_i = '0;
  logic        chk_valid_i = 1'b0;
  logic [6:0]  chk_reg_i = '0;
  logic        chk_valid_o, chk_hit_o, chk_pass_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ld_alias_table dut (.*);

  typedef struct packed {
    logic        ins_v;
    logic [6:0]  ins_reg;
    logic [31:0] ins_addr;
    logic        st_v;
    logic [31:0] st_addr;
    logic        chk_v;
    logic [6:0]  chk_reg;
    logic        hit;
    logic        pass;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd5,  1'b0, 1'b0, 8'd10}, // R10 empty after reset
    '{1'b1, 7'd5,  32'h100, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 1'b0, 8'd1},  // R1 insert
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd5,  1'b1, 1'b1, 8'd1},  // R1 pass
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd5,  1'b0, 1'b0, 8'd7},  // R7 consumed
    '{1'b1, 7'd6,  32'h200, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 1'b0, 8'd1},
    '{1'b0, 7'd0,  32'h0,   1'b1, 32'h204, 1'b0, 7'd0,  1'b0, 1'b0, 8'd2},  // R2 partial overlap
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd6,  1'b1, 1'b0, 8'd2},  // R2 invalid
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd6,  1'b1, 1'b0, 8'd7},  // R7 fail keeps
    '{1'b1, 7'd7,  32'h300, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 1'b0, 8'd1},
    '{1'b0, 7'd0,  32'h0,   1'b1, 32'h308, 1'b0, 7'd0,  1'b0, 1'b0, 8'd3},  // R3 next block
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd7,  1'b1, 1'b1, 8'd3},  // R3 survives
    '{1'b1, 7'd8,  32'h400, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 1'b0, 8'd4},
    '{1'b1, 7'd9,  32'h404, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 1'b0, 8'd4},
    '{1'b0, 7'd0,  32'h0,   1'b1, 32'h400, 1'b0, 7'd0,  1'b0, 1'b0, 8'd4},  // R4 one store
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd8,  1'b1, 1'b0, 8'd4},  // R4
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd9,  1'b1, 1'b0, 8'd4},  // R4
    '{1'b1, 7'd10, 32'h500, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 1'b0, 8'd5},
    '{1'b1, 7'd10, 32'h600, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 1'b0, 8'd5},  // R5 replace
    '{1'b0, 7'd0,  32'h0,   1'b1, 32'h500, 1'b0, 7'd0,  1'b0, 1'b0, 8'd5},  // R5 old block
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd10, 1'b1, 1'b1, 8'd5},  // R5 pass
    '{1'b1, 7'd11, 32'h700, 1'b1, 32'h706, 1'b0, 7'd0,  1'b0, 1'b0, 8'd9},  // R9 same cycle
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd11, 1'b1, 1'b0, 8'd9},  // R9
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd40, 1'b0, 1'b0, 8'd11}, // R11 never
    '{1'b1, 7'd12, 32'h800, 1'b0, 32'h0,   1'b1, 7'd12, 1'b0, 1'b0, 8'd10}, // R10 pre-state
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd12, 1'b1, 1'b1, 8'd10}  // R10
  };

  task automatic expect3(input logic v, input logic h, input logic p, input string req);
    checks++;
    if (chk_valid_o !== v || chk_hit_o !== h || chk_pass_o !== p) begin
      failures++;
      $display("FAIL %s: valid/hit/pass actual %b%b%b expected %b%b%b",
               req, chk_valid_o, chk_hit_o, chk_pass_o, v, h, p);
    end
  endtask

  task automatic drive_vec(input vec_t v);
    ld_valid_i  = v.ins_v;  ld_reg_i  = v.ins_reg; ld_addr_i = v.ins_addr;
    st_valid_i  = v.st_v;   st_addr_i = v.st_addr;
    chk_valid_i = v.chk_v;  chk_reg_i = v.chk_reg;
  endtask

  task automatic idle();
    ld_valid_i = 1'b0; st_valid_i = 1'b0; chk_valid_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic do_ins(input int r, input logic [31:0] a);
    @(negedge clk_i);
    ld_valid_i = 1'b1; ld_reg_i = 7'(r); ld_addr_i = a;
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_flush();
    @(negedge clk_i);
    flush_i = 1'b1;
    @(negedge clk_i);
    idle();
  endtask

  task automatic do_chk(input int r, input logic h, input logic p, input string req);
    @(negedge clk_i);
    chk_valid_i = 1'b1; chk_reg_i = 7'(r);
    @(negedge clk_i);
    idle();
    expect3(1'b1, h, p, req);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    expect3(1'b0, 1'b0, 1'b0, "R10");
    rst_ni = 1'b1;
    @(negedge clk_i);
    expect3(1'b0, 1'b0, 1'b0, "R10");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      if (i > 0) expect3(VECS[i-1].chk_v, VECS[i-1].hit, VECS[i-1].pass,
                         $sformatf("R%0d", VECS[i-1].req));
      drive_vec(VECS[i]);
    end
    @(negedge clk_i);
    expect3(VECS[NV-1].chk_v, VECS[NV-1].hit, VECS[NV-1].pass,
            $sformatf("R%0d", VECS[NV-1].req));
    idle();

    // R6: fill, then evict slots 0 and 1 in turn
    do_flush();
    for (int r = 1; r <= 8; r++) do_ins(r, 32'h1000 + 32'(r) * 32'h40);
    do_ins(9, 32'h2000);
    do_ins(10, 32'h2040);
    do_chk(1, 1'b0, 1'b0, "R6");
    do_chk(2, 1'b0, 1'b0, "R6");
    do_chk(3, 1'b1, 1'b1, "R6");
    do_chk(9, 1'b1, 1'b1, "R6");
    do_chk(10, 1'b1, 1'b1, "R6");

    // R8: flush empties and rewinds the pointer
    do_flush();
    do_chk(4, 1'b0, 1'b0, "R8");
    for (int r = 1; r <= 8; r++) do_ins(r, 32'h3000 + 32'(r) * 32'h40);
    do_ins(9, 32'h4000);
    do_chk(1, 1'b0, 1'b0, "R8");
    do_chk(3, 1'b1, 1'b1, "R8");
    do_chk(9, 1'b1, 1'b1, "R8");

    @(negedge clk_i);
    expect3(1'b0, 1'b0, 1'b0, "R1");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule